// File: doc/BRIEF.md
# Stop-and-Wait ARQ Sender

This block is the transmit end of a one-way link that uses stop-and-wait retransmission. It keeps exactly one data word in flight. Each word goes out as a packet that carries three things: the word, a sequence number and a count of how many times that word has already been resent. Every time a packet leaves, the block also raises a start request for an external timer. While it waits, two events can end the wait. A timeout from the timer makes it send the same packet again. An acknowledgement packet that names the current sequence number frees the sender to fetch the next word.

Acknowledgements arrive as a level on a port and have no strobe. The block therefore treats an acknowledgement as new only when the port value differs from the last value it captured. Words come from the source through a request/valid handshake. After reset the sequence number is 1 and the retry count is 0.

Top module: `arq_sender`

## Requirements
- R1: While reset is asserted, and right after it, the outputs are: pkt_seq = 1, pkt_retry = 0, pkt_valid = 0, start_timer = 0 and data_req = 1.
- R2: When data_req and data_valid are both high at a rising edge, data_in is captured. After that edge, pkt_valid and start_timer are high for exactly one cycle, pkt_data shows the word, pkt_retry is 0 and data_req is low.
- R3: No word is taken and no packet is sent while data_valid is low. A data_valid pulse while data_req is low has no effect on pkt_data or pkt_valid.
- R4: While waiting for an acknowledgement, a high timeout at a rising edge resends the packet. After that edge, pkt_valid and start_timer are high for one cycle, pkt_seq and pkt_data are unchanged, and pkt_retry is one higher.
- R5: pkt_retry is 4 bits wide and stays at 15 on further timeouts instead of wrapping.
- R6: A new acknowledgement whose 8-bit sequence field equals pkt_seq ends the wait. After the edge, pkt_seq is one higher (modulo 256), pkt_retry is 0, data_req is high and no packet is sent.
- R7: An acknowledgement value ({sequence, retry}) equal to the last captured one is not new. It causes no state change even when its sequence field matches pkt_seq.
- R8: A new acknowledgement whose sequence field differs from pkt_seq changes no output. Its value becomes the last captured one.
- R9: Timeout is evaluated before the acknowledgement. If both occur at the same edge, the packet is resent and the acknowledgement is not captured. If the acknowledgement is still held at a later edge with timeout low, it is taken then.
- R10: While data_req is high, timeout has no effect. An acknowledgement only updates the last captured value. pkt_seq, pkt_retry and pkt_valid do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_valid | input | 1 | Source offers a word |
| data_in | input | DATA_W (16) | Word from the source |
| data_req | output | 1 | Sender is ready for the next word |
| timeout | input | 1 | Expiry of the external timer |
| ack_seq | input | SEQ_W (8) | Sequence field of the acknowledgement packet |
| ack_retry | input | RETRY_W (4) | Retry field of the acknowledgement packet |
| pkt_valid | output | 1 | One-cycle strobe for each packet sent |
| pkt_seq | output | SEQ_W (8) | Sequence number of the current packet |
| pkt_retry | output | RETRY_W (4) | Resend count of the current packet |
| pkt_data | output | DATA_W (16) | Word carried by the current packet |
| start_timer | output | 1 | Timer start request, high with every send |

## Verification
The tests use acknowledgements whose sequence field mismatches the current frame, acknowledgements whose value repeats the last captured one, and acknowledgements that arrive in the same cycle as a timeout. Together these separate three things: the check on the sequence match, the check on value change, and the priority between the two events. Some acknowledgements and timeouts are applied while the sender is waiting for data, to show that they only refresh the captured value. A long run of timeouts shows the retry count stopping at its maximum. Data offered while a packet is outstanding shows that the handshake gates the source.

// File: rtl/arq_pkg.sv
package arq_pkg;

    // Sender phase: waiting for a source word, or waiting for an acknowledgement
    typedef enum logic {
        PH_FILL = 1'b0,
        PH_WAIT = 1'b1
    } arq_phase_e;

endpackage

// File: rtl/arq_ack_filter.sv
// Keeps the last captured acknowledgement value and flags a value change.
module arq_ack_filter #(
    parameter int SEQ_W   = 8,
    parameter int RETRY_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SEQ_W-1:0]   ack_seq,
    input  logic [RETRY_W-1:0] ack_retry,
    input  logic               cap_en,
    output logic               ack_new
);
    localparam int ACK_W = SEQ_W + RETRY_W;

    logic [ACK_W-1:0] last_d, last_q;
    logic [ACK_W-1:0] ack_word;

    assign ack_word = {ack_seq, ack_retry};
    assign ack_new  = (ack_word != last_q);

    always_comb begin
        last_d = last_q;
        if (cap_en && ack_new) begin
            last_d = ack_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= '0;
        end else begin
            last_q <= last_d;
        end
    end
endmodule

// File: rtl/arq_retry_count.sv
// Saturating resend counter with a synchronous clear.
module arq_retry_count #(
    parameter int RETRY_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               inc,
    output logic [RETRY_W-1:0] count
);
    localparam logic [RETRY_W-1:0] CNT_MAX = '1;

    logic [RETRY_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc && (cnt_q != CNT_MAX)) begin
            cnt_d = cnt_q + RETRY_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/arq_sender.sv
// Stop-and-wait transmitter: one word in flight, resend on timeout,
// advance on a matching new acknowledgement.
module arq_sender
    import arq_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int SEQ_W   = 8,
    parameter int RETRY_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               data_valid,
    input  logic [DATA_W-1:0]  data_in,
    output logic               data_req,
    input  logic               timeout,
    input  logic [SEQ_W-1:0]   ack_seq,
    input  logic [RETRY_W-1:0] ack_retry,
    output logic               pkt_valid,
    output logic [SEQ_W-1:0]   pkt_seq,
    output logic [RETRY_W-1:0] pkt_retry,
    output logic [DATA_W-1:0]  pkt_data,
    output logic               start_timer
);
    localparam logic [SEQ_W-1:0] SEQ_FIRST = SEQ_W'(1);

    typedef struct packed {
        arq_phase_e         phase;
        logic [SEQ_W-1:0]   frame;
        logic [DATA_W-1:0]  word;
        logic               send;
        logic               kick;
    } snd_state_t;

    snd_state_t cur_q, nxt_d;

    logic ack_new;
    logic ack_cap;
    logic retry_inc;
    logic retry_clr;
    logic seq_hit;

    arq_ack_filter #(
        .SEQ_W   (SEQ_W),
        .RETRY_W (RETRY_W)
    ) i_ack_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack_seq   (ack_seq),
        .ack_retry (ack_retry),
        .cap_en    (ack_cap),
        .ack_new   (ack_new)
    );

    arq_retry_count #(
        .RETRY_W (RETRY_W)
    ) i_retry_count (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (retry_clr),
        .inc   (retry_inc),
        .count (pkt_retry)
    );

    assign seq_hit = (ack_seq == cur_q.frame);

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.send = 1'b0;
        nxt_d.kick = 1'b0;
        ack_cap    = 1'b0;
        retry_inc  = 1'b0;
        retry_clr  = 1'b0;

        unique case (cur_q.phase)
            PH_FILL: begin
                // acknowledgements only refresh the captured value here
                ack_cap = 1'b1;
                if (data_valid) begin
                    nxt_d.word  = data_in;
                    nxt_d.send  = 1'b1;
                    nxt_d.kick  = 1'b1;
                    nxt_d.phase = PH_WAIT;
                end
            end
            PH_WAIT: begin
                if (timeout) begin
                    // timeout first: resend, leave the acknowledgement pending
                    retry_inc  = 1'b1;
                    nxt_d.send = 1'b1;
                    nxt_d.kick = 1'b1;
                end else begin
                    ack_cap = 1'b1;
                    if (ack_new && seq_hit) begin
                        nxt_d.frame = cur_q.frame + SEQ_W'(1);
                        nxt_d.phase = PH_FILL;
                        retry_clr   = 1'b1;
                    end
                end
            end
            default: begin
                nxt_d.phase = PH_FILL;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.phase <= PH_FILL;
            cur_q.frame <= SEQ_FIRST;
            cur_q.word  <= '0;
            cur_q.send  <= 1'b0;
            cur_q.kick  <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign data_req    = (cur_q.phase == PH_FILL);
    assign pkt_valid   = cur_q.send;
    assign start_timer = cur_q.kick;
    assign pkt_seq     = cur_q.frame;
    assign pkt_data    = cur_q.word;

endmodule

// File: rtl/arq_sender_chk.sv
// Port-level properties of the sender, bound into every instance.
module arq_sender_chk #(
    parameter int DATA_W  = 16,
    parameter int SEQ_W   = 8,
    parameter int RETRY_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               data_valid,
    input logic               data_req,
    input logic               timeout,
    input logic               pkt_valid,
    input logic [SEQ_W-1:0]   pkt_seq,
    input logic [RETRY_W-1:0] pkt_retry,
    input logic [DATA_W-1:0]  pkt_data,
    input logic               start_timer
);
    localparam logic [RETRY_W-1:0] RMAX = '1;

    // R2: every packet sent comes with a timer start request
    a_r2_timer_on_send: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> start_timer);

    // R3 and R10: while data is requested, a send follows only an offered word
    a_r10_fill_sends_on_data: assert property (@(posedge clk) disable iff (!rst_n)
        data_req |=> (pkt_valid == $past(data_valid)));

    // R4: a timeout while waiting resends the same sequence number and word
    a_r4_resend_same: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_req && timeout) |=> (pkt_valid && $stable(pkt_seq) && $stable(pkt_data)));

    // R5: the retry count never wraps from its maximum to a nonzero value
    a_r5_retry_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_retry == RMAX) |=> (pkt_retry == RMAX || pkt_retry == '0));

    // R6: the sender returns to requesting data only with a cleared retry count
    a_r6_accept_clears_retry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_req) |-> (pkt_retry == '0));

    // R6: a data request never appears together with a packet strobe
    a_r6_no_send_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        data_req |-> !pkt_valid);
endmodule

bind arq_sender arq_sender_chk #(
    .DATA_W  (DATA_W),
    .SEQ_W   (SEQ_W),
    .RETRY_W (RETRY_W)
) i_arq_sender_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .data_valid  (data_valid),
    .data_req    (data_req),
    .timeout     (timeout),
    .pkt_valid   (pkt_valid),
    .pkt_seq     (pkt_seq),
    .pkt_retry   (pkt_retry),
    .pkt_data    (pkt_data),
    .start_timer (start_timer)
);

// File: tb/test_arq_sender.sv
`timescale 1ns/100ps
module test_arq_sender;
    localparam int DATA_W  = 16;
    localparam int SEQ_W   = 8;
    localparam int RETRY_W = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               data_valid = 1'b0;
    logic [DATA_W-1:0]  data_in = '0;
    logic               data_req;
    logic               timeout = 1'b0;
    logic [SEQ_W-1:0]   ack_seq = '0;
    logic [RETRY_W-1:0] ack_retry = '0;
    logic               pkt_valid;
    logic [SEQ_W-1:0]   pkt_seq;
    logic [RETRY_W-1:0] pkt_retry;
    logic [DATA_W-1:0]  pkt_data;
    logic               start_timer;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    arq_sender #(.DATA_W(DATA_W), .SEQ_W(SEQ_W), .RETRY_W(RETRY_W)) i_arq_sender (
        .clk(clk), .rst_n(rst_n), .data_valid(data_valid), .data_in(data_in),
        .data_req(data_req), .timeout(timeout), .ack_seq(ack_seq), .ack_retry(ack_retry),
        .pkt_valid(pkt_valid), .pkt_seq(pkt_seq), .pkt_retry(pkt_retry),
        .pkt_data(pkt_data), .start_timer(start_timer)
    );

    typedef struct packed {
        logic        dv;
        logic [15:0] din;
        logic        to;
        logic [7:0]  aseq;
        logic [3:0]  aret;
        logic        e_req;
        logic        e_pv;
        logic        e_st;
        logic [7:0]  e_seq;
        logic [3:0]  e_ret;
        logic [15:0] e_dat;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 18;
    // inputs for one edge, then outputs expected after it
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'h0000, 1'b1, 8'd0, 4'd0, 1'b1, 1'b0, 1'b0, 8'd1, 4'd0, 16'h0000, 8'd10}, // R10 timeout ignored while filling
        '{1'b1, 16'hA1A1, 1'b0, 8'd0, 4'd0, 1'b0, 1'b1, 1'b1, 8'd1, 4'd0, 16'hA1A1, 8'd2},  // R2 first word sent
        '{1'b0, 16'h0000, 1'b0, 8'd0, 4'd0, 1'b0, 1'b0, 1'b0, 8'd1, 4'd0, 16'hA1A1, 8'd2},  // R2 strobe lasts one cycle
        '{1'b0, 16'h0000, 1'b1, 8'd0, 4'd0, 1'b0, 1'b1, 1'b1, 8'd1, 4'd1, 16'hA1A1, 8'd4},  // R4 resend
        '{1'b0, 16'h0000, 1'b0, 8'd0, 4'd0, 1'b0, 1'b0, 1'b0, 8'd1, 4'd1, 16'hA1A1, 8'd4},  // R4 strobe ends
        '{1'b0, 16'h0000, 1'b0, 8'd2, 4'd0, 1'b0, 1'b0, 1'b0, 8'd1, 4'd1, 16'hA1A1, 8'd8},  // R8 mismatched ack
        '{1'b0, 16'h0000, 1'b1, 8'd2, 4'd0, 1'b0, 1'b1, 1'b1, 8'd1, 4'd2, 16'hA1A1, 8'd4},  // R4 second resend
        '{1'b0, 16'h0000, 1'b1, 8'd1, 4'd2, 1'b0, 1'b1, 1'b1, 8'd1, 4'd3, 16'hA1A1, 8'd9},  // R9 timeout beats ack
        '{1'b0, 16'h0000, 1'b0, 8'd1, 4'd2, 1'b1, 1'b0, 1'b0, 8'd2, 4'd0, 16'hA1A1, 8'd9},  // R9 R6 held ack taken
        '{1'b0, 16'h0000, 1'b1, 8'd2, 4'd0, 1'b1, 1'b0, 1'b0, 8'd2, 4'd0, 16'hA1A1, 8'd10}, // R10 ack only captured
        '{1'b1, 16'hB2B2, 1'b0, 8'd2, 4'd0, 1'b0, 1'b1, 1'b1, 8'd2, 4'd0, 16'hB2B2, 8'd2},  // R2 second word
        '{1'b0, 16'h0000, 1'b0, 8'd2, 4'd0, 1'b0, 1'b0, 1'b0, 8'd2, 4'd0, 16'hB2B2, 8'd7},  // R7 repeated value ignored
        '{1'b0, 16'h0000, 1'b1, 8'd2, 4'd0, 1'b0, 1'b1, 1'b1, 8'd2, 4'd1, 16'hB2B2, 8'd4},  // R4 resend frame 2
        '{1'b0, 16'h0000, 1'b0, 8'd2, 4'd0, 1'b0, 1'b0, 1'b0, 8'd2, 4'd1, 16'hB2B2, 8'd7},  // R7 still ignored
        '{1'b0, 16'h0000, 1'b0, 8'd2, 4'd1, 1'b1, 1'b0, 1'b0, 8'd3, 4'd0, 16'hB2B2, 8'd6},  // R6 changed value accepted
        '{1'b0, 16'h0000, 1'b0, 8'd2, 4'd1, 1'b1, 1'b0, 1'b0, 8'd3, 4'd0, 16'hB2B2, 8'd3},  // R3 waits for data
        '{1'b1, 16'hC3C3, 1'b0, 8'd2, 4'd1, 1'b0, 1'b1, 1'b1, 8'd3, 4'd0, 16'hC3C3, 8'd2},  // R2 third word
        '{1'b1, 16'hDDDD, 1'b0, 8'd2, 4'd1, 1'b0, 1'b0, 1'b0, 8'd3, 4'd0, 16'hC3C3, 8'd3}   // R3 offer while waiting ignored
    };

    task automatic check(input string tag, input logic req, input logic pv, input logic st,
                         input logic [7:0] sq, input logic [3:0] rt, input logic [15:0] dt);
        total++;
        if (data_req !== req || pkt_valid !== pv || start_timer !== st ||
            pkt_seq !== sq || pkt_retry !== rt || pkt_data !== dt) begin
            bad++;
            $display("FAIL %s: got req=%b pv=%b st=%b seq=%0d ret=%0d dat=%h, expected req=%b pv=%b st=%b seq=%0d ret=%0d dat=%h",
                     tag, data_req, pkt_valid, start_timer, pkt_seq, pkt_retry, pkt_data,
                     req, pv, st, sq, rt, dt);
        end
    endtask

    task automatic step(input logic dv, input logic [15:0] din, input logic to,
                        input logic [7:0] as, input logic [3:0] ar);
        @(negedge clk);
        data_valid = dv;
        data_in    = din;
        timeout    = to;
        ack_seq    = as;
        ack_retry  = ar;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 in reset", 1'b1, 1'b0, 1'b0, 8'd1, 4'd0, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 after release", 1'b1, 1'b0, 1'b0, 8'd1, 4'd0, 16'h0000);

        for (int k = 0; k < NV; k++) begin
            step(VECS[k].dv, VECS[k].din, VECS[k].to, VECS[k].aseq, VECS[k].aret);
            check($sformatf("R%0d vector %0d", VECS[k].rq, k), VECS[k].e_req, VECS[k].e_pv,
                  VECS[k].e_st, VECS[k].e_seq, VECS[k].e_ret, VECS[k].e_dat);
        end

        // R5: back-to-back timeouts count up to 15 and hold there
        for (int n = 1; n <= 17; n++) begin
            step(1'b0, 16'h0000, 1'b1, 8'd2, 4'd1);
            check($sformatf("R5 timeout %0d", n), 1'b0, 1'b1, 1'b1, 8'd3,
                  (n > 15) ? 4'd15 : 4'(n), 16'hC3C3);
        end
        step(1'b0, 16'h0000, 1'b0, 8'd2, 4'd1);
        check("R5 quiet after saturation", 1'b0, 1'b0, 1'b0, 8'd3, 4'd15, 16'hC3C3);

        // R6: matching ack from saturation clears the count
        step(1'b0, 16'h0000, 1'b0, 8'd3, 4'd15);
        check("R6 accept from saturation", 1'b1, 1'b0, 1'b0, 8'd4, 4'd0, 16'hC3C3);

        // R1: reset in the middle of operation
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 mid-run reset", 1'b1, 1'b0, 1'b0, 8'd1, 4'd0, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b1, 16'h5A5A, 1'b0, 8'd0, 4'd0);
        check("R2 send after reset", 1'b0, 1'b1, 1'b1, 8'd1, 4'd0, 16'h5A5A);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got no finish, expected finish within 20000 cycles");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule